// File: doc/BRIEF.md
# Adaptive Threshold Proximity Comparator

This block serves a single capacitive sensing channel. It receives a stream of 12-bit conversion results, each marked by a one-cycle valid strobe. From these it keeps an exponentially weighted running average with a selectable time constant. Around that average it places a sensitivity band and raises one active-high detect flag when the newest sample meets the condition selected by the comparison mode. Four modes are available: below the band, above the band, inside it, or outside it.

While the detect flag is high, an optional hysteresis of a quarter of the sensitivity widens its release bound. Two independent counters watch how long the data stays outside the band. One counts samples on the side facing the active threshold, the other counts samples on the opposite side. When a counter reaches its programmed power of two, the average is snapped onto the current sample, so a lasting shift is absorbed quickly.

A fixed mode replaces the adaptive band with one programmed 12-bit level. The average keeps tracking in that mode, and the current average is always presented on an output.

Top module: `adaptive_prox_cmp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `detect` is 0 and `avg_out` is 0.
- R2: The first valid sample after reset loads the average with that sample exactly and leaves `detect` at 0. No comparison is made for that sample.
- R3: For every later valid sample the accumulator, which holds 12 integer and 16 fraction bits, advances by (sample·2^16 − accumulator) arithmetically shifted right by `cfg_settle`+1. `avg_out` is the integer part, truncated. Both outputs change on the clock edge that samples the strobe.
- R4: In adaptive mode the upper threshold is hi = min(avg+sens, 4095) and the lower is lo = max(avg−sens, 0). Both are formed from the average before the current sample is folded in. With `cfg_mode`=01, `detect` rises when data > hi.
- R5: With `cfg_mode`=00 in adaptive mode, `detect` rises when data < lo.
- R6: With `cfg_mode`=10, `detect` is set when lo < data < hi. With `cfg_mode`=11, it is set when data < lo or data > hi.
- R7: In adaptive mode, h = floor(sens/4) applies while `detect` is 1. Mode 00 holds while data < lo+h. Mode 01 holds while data > hi−h. Mode 10 holds while lo−h < data < hi+h. Mode 11 holds while data < lo+h or data > hi−h. All these bounds saturate at 0 and 4095. `cfg_hyst_off`=1 makes h = 0.
- R8: With `cfg_fixed`=1, `detect` is data > `cfg_fix_thr` when `cfg_mode` bit 0 is 1, and data < `cfg_fix_thr` when it is 0. Bit 1 is ignored, and neither hysteresis nor timeouts act.
- R9: Samples above hi in mode 01, below lo in mode 00, or on either side in modes 10 and 11 count as approaching. When the consecutive count reaches 2^`cfg_tmo_appr`, the average is replaced by that sample.
- R10: Samples on the side away from the threshold in modes 00 and 01 count as receding. The average snaps after 2^`cfg_tmo_rec` of them. Window modes never count receding samples.
- R11: When `cfg_tmo_appr` and `cfg_tmo_rec` are both 0, no snap ever occurs.
- R12: A counter returns to zero on any valid sample that is not on its side, including samples inside lo..hi, and on any snap. Counters advance only on valid samples.
- R13: Threshold arithmetic saturates. An average near 4095 or near 0 never produces a wrapped threshold.
- R14: In a cycle without a valid strobe, `detect` and `avg_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one cycle per conversion |
| smp_data | input | 12 | Conversion result |
| cfg_fixed | input | 1 | 1 selects fixed-level comparison |
| cfg_mode | input | 2 | Comparison mode: 00 below, 01 above, 10 inside band, 11 outside band |
| cfg_settle | input | 4 | Averaging exponent; time constant 2^(value+1) samples |
| cfg_sens | input | 8 | Band half-width in data LSBs |
| cfg_hyst_off | input | 1 | 1 removes the hysteresis |
| cfg_fix_thr | input | 12 | Level used in fixed mode |
| cfg_tmo_appr | input | 4 | Exponent of the approaching timeout |
| cfg_tmo_rec | input | 4 | Exponent of the receding timeout |
| detect | output | 1 | Proximity flag |
| avg_out | output | 12 | Integer part of the running average |

## Verification
Every result is registered once. A sample strobed in one cycle therefore shows its effect on `detect` and `avg_out` one clock edge later, and a snap caused by a timeout appears in that same update. The bench pairs each strobe with an idle cycle. It pushes the expected pair into a queue when it drives the strobe, and pops and compares at the falling edge after the capturing rising edge. Idle stretches are checked at every falling edge to show the outputs hold with no strobe present.

// File: rtl/apc_pkg.sv
package apc_pkg;

    localparam int DATA_W   = 12;
    localparam int SENS_W   = 8;
    localparam int SETTLE_W = 4;
    localparam int TMO_W    = 4;
    localparam int FRAC_W   = 1 << SETTLE_W;
    localparam int ACC_W    = DATA_W + FRAC_W;
    localparam int CNT_W    = 1 << TMO_W;
    localparam int N_DIR    = 2;
    localparam logic [DATA_W-1:0] DATA_MAX = '1;

    typedef enum logic [1:0] {
        CMP_BELOW  = 2'b00,
        CMP_ABOVE  = 2'b01,
        CMP_INSIDE = 2'b10,
        CMP_OUTSIDE = 2'b11
    } cmp_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] hyst;
        logic              above;
        logic              below;
    } band_t;

    function automatic logic [DATA_W-1:0] sat_add(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
        logic [DATA_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[DATA_W] ? DATA_MAX : s[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] sat_sub(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
        return (a >= b) ? (a - b) : '0;
    endfunction

endpackage

// File: rtl/apc_avg.sv
module apc_avg
    import apc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FRAC_W,
    parameter int SW = SETTLE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic          load,
    input  logic [DW-1:0] data,
    input  logic [SW-1:0] settle,
    output logic [DW-1:0] avg
);
    localparam int AW = DW + FW;

    logic [AW-1:0]        acc_q;
    logic [AW-1:0]        target;
    logic [AW-1:0]        acc_n;
    logic signed [AW:0]   delta;
    logic signed [AW:0]   step;
    logic [SW:0]          shamt;

    always_comb begin
        target = {data, {FW{1'b0}}};
        delta  = $signed({1'b0, target}) - $signed({1'b0, acc_q});
        shamt  = {1'b0, settle} + (SW+1)'(1);
        step   = delta >>> shamt;
        acc_n  = acc_q + step[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (load) acc_q <= target;
        else if (upd)  acc_q <= acc_n;
    end

    assign avg = acc_q[AW-1 -: DW];

endmodule

// File: rtl/apc_band.sv
module apc_band
    import apc_pkg::*;
(
    input  logic [DATA_W-1:0] avg,
    input  logic [DATA_W-1:0] data,
    input  logic [SENS_W-1:0] sens,
    input  logic              hyst_off,
    input  logic              fixed,
    output band_t             band
);
    logic [DATA_W-1:0] sens_ext;

    always_comb begin
        sens_ext   = DATA_W'(sens);
        band.lo    = sat_sub(avg, sens_ext);
        band.hi    = sat_add(avg, sens_ext);
        band.hyst  = (fixed || hyst_off) ? '0 : DATA_W'(sens >> 2);
        band.above = data > band.hi;
        band.below = data < band.lo;
    end

endmodule

// File: rtl/apc_detect.sv
module apc_detect
    import apc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              clear,
    input  logic              fixed,
    input  cmp_mode_e         mode,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] fix_thr,
    input  band_t             band,
    output logic              det
);
    logic              det_q;
    logic              det_n;
    logic [DATA_W-1:0] lo_wide;
    logic [DATA_W-1:0] hi_wide;
    logic [DATA_W-1:0] lo_rel;
    logic [DATA_W-1:0] hi_rel;

    always_comb begin
        lo_wide = sat_sub(band.lo, band.hyst);
        hi_wide = sat_add(band.hi, band.hyst);
        lo_rel  = sat_add(band.lo, band.hyst);
        hi_rel  = sat_sub(band.hi, band.hyst);
        if (fixed) begin
            det_n = mode[0] ? (data > fix_thr) : (data < fix_thr);
        end else begin
            unique case (mode)
                CMP_BELOW:   det_n = det_q ? (data < lo_rel) : (data < band.lo);
                CMP_ABOVE:   det_n = det_q ? (data > hi_rel) : (data > band.hi);
                CMP_INSIDE:  det_n = det_q ? (data > lo_wide && data < hi_wide)
                                           : (data > band.lo && data < band.hi);
                CMP_OUTSIDE: det_n = det_q ? (data < lo_rel || data > hi_rel)
                                           : (data < band.lo || data > band.hi);
                default:     det_n = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) det_q <= 1'b0;
        else if (upd)     det_q <= det_n;
    end

    assign det = det_q;

endmodule

// File: rtl/apc_tmo_cnt.sv
module apc_tmo_cnt
    import apc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int EW = TMO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          enable,
    input  logic          outside,
    input  logic          clr,
    input  logic [EW-1:0] exp_sel,
    output logic          elapsed
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] limit;

    always_comb begin
        limit   = CW'(1) << exp_sel;
        cnt_inc = cnt_q + CW'(1);
        elapsed = step && enable && outside && (cnt_inc >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            if (!enable || !outside || clr) cnt_q <= '0;
            else                            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/adaptive_prox_cmp.sv
module adaptive_prox_cmp
    import apc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [DATA_W-1:0]   smp_data,
    input  logic                cfg_fixed,
    input  logic [1:0]          cfg_mode,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic [SENS_W-1:0]   cfg_sens,
    input  logic                cfg_hyst_off,
    input  logic [DATA_W-1:0]   cfg_fix_thr,
    input  logic [TMO_W-1:0]    cfg_tmo_appr,
    input  logic [TMO_W-1:0]    cfg_tmo_rec,
    output logic                detect,
    output logic [DATA_W-1:0]   avg_out
);
    localparam int DIR_APPR = 0;
    localparam int DIR_REC  = 1;

    cmp_mode_e                   mode;
    logic                        seeded_q;
    logic                        step;
    logic                        seed;
    logic                        snap;
    logic                        tmo_en;
    logic [DATA_W-1:0]           avg;
    band_t                       band;
    logic [N_DIR-1:0]            dir_out;
    logic [N_DIR-1:0]            dir_hit;
    logic [N_DIR-1:0][TMO_W-1:0] dir_exp;

    assign mode = cmp_mode_e'(cfg_mode);
    assign step = smp_valid && seeded_q;
    assign seed = smp_valid && !seeded_q;

    always_ff @(posedge clk) begin
        if (rst)       seeded_q <= 1'b0;
        else if (seed) seeded_q <= 1'b1;
    end

    apc_avg u_avg (
        .clk    (clk),
        .rst    (rst),
        .upd    (step),
        .load   (seed || snap),
        .data   (smp_data),
        .settle (cfg_settle),
        .avg    (avg)
    );

    apc_band u_band (
        .avg      (avg),
        .data     (smp_data),
        .sens     (cfg_sens),
        .hyst_off (cfg_hyst_off),
        .fixed    (cfg_fixed),
        .band     (band)
    );

    apc_detect u_det (
        .clk     (clk),
        .rst     (rst),
        .upd     (step),
        .clear   (seed),
        .fixed   (cfg_fixed),
        .mode    (mode),
        .data    (smp_data),
        .fix_thr (cfg_fix_thr),
        .band    (band),
        .det     (detect)
    );

    // Classify an out-of-band sample as facing the active threshold or not.
    always_comb begin
        unique case (mode)
            CMP_BELOW: begin
                dir_out[DIR_APPR] = band.below;
                dir_out[DIR_REC]  = band.above;
            end
            CMP_ABOVE: begin
                dir_out[DIR_APPR] = band.above;
                dir_out[DIR_REC]  = band.below;
            end
            default: begin
                dir_out[DIR_APPR] = band.above || band.below;
                dir_out[DIR_REC]  = 1'b0;
            end
        endcase
        dir_exp[DIR_APPR] = cfg_tmo_appr;
        dir_exp[DIR_REC]  = cfg_tmo_rec;
        tmo_en = !cfg_fixed && ({cfg_tmo_appr, cfg_tmo_rec} != '0);
    end

    for (genvar gi = 0; gi < N_DIR; gi++) begin : g_tmo
        apc_tmo_cnt u_cnt (
            .clk     (clk),
            .rst     (rst),
            .step    (step),
            .enable  (tmo_en),
            .outside (dir_out[gi]),
            .clr     (snap),
            .exp_sel (dir_exp[gi]),
            .elapsed (dir_hit[gi])
        );
    end

    assign snap    = |dir_hit;
    assign avg_out = avg;

endmodule

// File: rtl/apc_checker.sv
module apc_checker
    import apc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_data,
    input logic              cfg_fixed,
    input logic [1:0]        cfg_mode,
    input logic [DATA_W-1:0] cfg_fix_thr,
    input logic [TMO_W-1:0]  cfg_tmo_appr,
    input logic [TMO_W-1:0]  cfg_tmo_rec,
    input logic              detect,
    input logic [DATA_W-1:0] avg_out,
    input logic              seeded,
    input logic              snap
);
    logic rst_q = 1'b0;

    always @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_CLEAR: assert (detect == 1'b0 && avg_out == '0); // R1
        end
        rst_q <= rst;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(detect) && $stable(avg_out))); // R14

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !seeded) |=> (avg_out == $past(smp_data) && !detect)); // R2

    AST_FIXED_CMP: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && seeded && cfg_fixed) |=>
            (detect == ($past(cfg_mode[0]) ? ($past(smp_data) > $past(cfg_fix_thr))
                                           : ($past(smp_data) < $past(cfg_fix_thr))))); // R8

    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        snap |=> (avg_out == $past(smp_data))); // R9

    AST_SNAP_ENABLED: assert property (@(posedge clk) disable iff (rst)
        snap |-> (smp_valid && !cfg_fixed && ({cfg_tmo_appr, cfg_tmo_rec} != '0))); // R11

endmodule

bind adaptive_prox_cmp apc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .smp_valid    (smp_valid),
    .smp_data     (smp_data),
    .cfg_fixed    (cfg_fixed),
    .cfg_mode     (cfg_mode),
    .cfg_fix_thr  (cfg_fix_thr),
    .cfg_tmo_appr (cfg_tmo_appr),
    .cfg_tmo_rec  (cfg_tmo_rec),
    .detect       (detect),
    .avg_out      (avg_out),
    .seeded       (seeded_q),
    .snap         (snap)
);

// File: tb/adaptive_prox_cmp_tb.sv
module adaptive_prox_cmp_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        cfg_fixed = 1'b0;
    logic [1:0]  cfg_mode = 2'b01;
    logic [3:0]  cfg_settle = 4'd15;
    logic [7:0]  cfg_sens = 8'd40;
    logic        cfg_hyst_off = 1'b0;
    logic [11:0] cfg_fix_thr = 12'd1500;
    logic [3:0]  cfg_tmo_appr = 4'd0;
    logic [3:0]  cfg_tmo_rec = 4'd0;
    logic        detect;
    logic [11:0] avg_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    adaptive_prox_cmp u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_fixed(cfg_fixed), .cfg_mode(cfg_mode), .cfg_settle(cfg_settle),
        .cfg_sens(cfg_sens), .cfg_hyst_off(cfg_hyst_off), .cfg_fix_thr(cfg_fix_thr),
        .cfg_tmo_appr(cfg_tmo_appr), .cfg_tmo_rec(cfg_tmo_rec),
        .detect(detect), .avg_out(avg_out)
    );

    typedef struct {
        bit    det;
        int    avg;
        string tag;
    } exp_t;

    exp_t   sb_q[$];
    int     n_tests = 0;
    int     n_fail  = 0;
    bit     finished = 1'b0;
    bit     due = 1'b0;

    longint m_acc  = 0;
    bit     m_det  = 1'b0;
    bit     m_seed = 1'b0;
    int     m_apr  = 0;
    int     m_rec  = 0;

    function automatic int ssub(int a, int b);
        return (a > b) ? a - b : 0;
    endfunction

    function automatic int sadd(int a, int b);
        return (a + b > 4095) ? 4095 : a + b;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pop the expected pair one edge after each strobe.
    always @(posedge clk) due <= smp_valid;

    always @(negedge clk) begin
        if (due) begin
            if (sb_q.size() == 0) begin
                check("queue underflow", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " detect"}, int'(detect), int'(e.det));
                check({e.tag, " avg"}, int'(avg_out), e.avg);
            end
        end
    end

    task automatic model_reset();
        m_acc = 0; m_det = 1'b0; m_seed = 1'b0; m_apr = 0; m_rec = 0;
    endtask

    task automatic send(int d, string tag);
        exp_t   e;
        int     avg, lo, hi, h;
        bit     en, a_out, r_out, snap;
        longint delta;
        @(negedge clk);
        avg = int'(m_acc >>> 16);
        if (!m_seed) begin
            m_seed = 1'b1;
            m_acc  = longint'(d) <<< 16;
            m_det  = 1'b0;
        end else begin
            lo = ssub(avg, cfg_sens);
            hi = sadd(avg, cfg_sens);
            h  = (cfg_fixed || cfg_hyst_off) ? 0 : cfg_sens / 4;
            if (cfg_fixed) begin
                m_det = cfg_mode[0] ? (d > cfg_fix_thr) : (d < cfg_fix_thr);
            end else begin
                case (cfg_mode)
                    2'b00: m_det = m_det ? (d < sadd(lo, h)) : (d < lo);
                    2'b01: m_det = m_det ? (d > ssub(hi, h)) : (d > hi);
                    2'b10: m_det = m_det ? (d > ssub(lo, h) && d < sadd(hi, h)) : (d > lo && d < hi);
                    default: m_det = m_det ? (d < sadd(lo, h) || d > ssub(hi, h)) : (d < lo || d > hi);
                endcase
            end
            en = !cfg_fixed && (cfg_tmo_appr != 0 || cfg_tmo_rec != 0);
            case (cfg_mode)
                2'b00: begin a_out = d < lo; r_out = d > hi; end
                2'b01: begin a_out = d > hi; r_out = d < lo; end
                default: begin a_out = (d < lo) || (d > hi); r_out = 1'b0; end
            endcase
            snap = (en && a_out && (m_apr + 1 >= (1 << cfg_tmo_appr))) ||
                   (en && r_out && (m_rec + 1 >= (1 << cfg_tmo_rec)));
            m_apr = (!en || !a_out || snap) ? 0 : m_apr + 1;
            m_rec = (!en || !r_out || snap) ? 0 : m_rec + 1;
            if (snap) begin
                m_acc = longint'(d) <<< 16;
            end else begin
                delta = (longint'(d) <<< 16) - m_acc;
                m_acc = m_acc + (delta >>> (cfg_settle + 1));
            end
        end
        e.det = m_det;
        e.avg = int'(m_acc >>> 16);
        e.tag = tag;
        smp_data  = 12'(d);
        smp_valid = 1'b1;
        sb_q.push_back(e);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic hold_check(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R14 idle detect", int'(detect), int'(m_det));
            check("R14 idle avg", int'(avg_out), int'(m_acc >>> 16));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset detect", int'(detect), 0);
        check("R1 reset avg", int'(avg_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset avg", int'(avg_out), 0);

        send(1000, "R2 seed");
        hold_check(3);

        // Positive mode with hysteresis, slow average
        send(1030, "R4 inside band");
        send(1041, "R4 above hi");
        send(1035, "R7 held by hysteresis");
        send(1030, "R7 released");
        cfg_hyst_off = 1'b1;
        send(1041, "R7 hyst off set");
        send(1039, "R7 hyst off release");
        cfg_hyst_off = 1'b0;

        cfg_mode = 2'b00;
        send(1000, "R5 inside");
        send(950, "R5 below lo");
        send(968, "R7 neg held");
        send(990, "R5 released");

        cfg_mode = 2'b10;
        send(1005, "R6 in-window set");
        send(1039, "R7 in-window held");
        send(1100, "R6 in-window clear");
        cfg_mode = 2'b11;
        send(1100, "R6 out-window set");
        send(1000, "R6 out-window clear");
        send(900, "R6 out-window low");
        hold_check(2);

        // Fixed level
        cfg_fixed = 1'b1;
        cfg_mode  = 2'b01;
        send(1501, "R8 fixed above");
        send(1499, "R8 fixed no hyst");
        cfg_mode = 2'b11;
        send(1600, "R8 fixed bit1 ignored");
        cfg_mode = 2'b00;
        send(1400, "R8 fixed below");
        send(1500, "R8 fixed equal");
        cfg_fixed = 1'b0;

        // Averaging dynamics
        do_reset();
        cfg_mode = 2'b01; cfg_settle = 4'd0;
        send(1000, "R2 reseed");
        send(2000, "R3 settle0 a");
        send(2000, "R3 settle0 b");
        send(2000, "R3 settle0 c");
        cfg_settle = 4'd2;
        send(1000, "R3 settle2 a");
        send(1000, "R3 settle2 b");
        send(1003, "R3 settle2 c");

        // Timeouts
        do_reset();
        cfg_settle = 4'd15; cfg_mode = 2'b01;
        cfg_tmo_appr = 4'd2; cfg_tmo_rec = 4'd1;
        send(1000, "R2 timeout seed");
        send(1200, "R9 appr 1");
        send(1200, "R9 appr 2");
        send(1200, "R9 appr 3");
        send(1200, "R9 appr snap");
        send(1100, "R10 rec 1");
        send(1100, "R10 rec snap");
        send(1300, "R12 count 1");
        send(1300, "R12 count 2");
        send(1300, "R12 count 3");
        send(1100, "R12 inside clears");
        send(1300, "R12 recount 1");
        send(1300, "R12 recount 2");
        send(1300, "R12 recount 3");
        cfg_mode = 2'b10; cfg_tmo_appr = 4'd3; cfg_tmo_rec = 4'd0;
        send(900, "R10 window no rec 1");
        send(900, "R10 window no rec 2");
        send(900, "R10 window no rec 3");
        cfg_mode = 2'b01; cfg_tmo_appr = 4'd0; cfg_tmo_rec = 4'd0;
        for (int i = 0; i < 5; i++) send(3000, "R11 timeouts off");

        // Saturation at both ends
        cfg_settle = 4'd0;
        for (int i = 0; i < 14; i++) send(10, "R3 approach low");
        cfg_mode = 2'b00;
        send(0, "R13 low saturation");
        for (int i = 0; i < 14; i++) send(4095, "R3 approach high");
        cfg_mode = 2'b01;
        send(4095, "R13 high saturation");
        hold_check(3);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule